// File: doc/BRIEF.md
# Oscillator Switch and Resume-Delay Controller

This block holds an 8-bit clock configuration register on a small write port and runs the sequencer that decides when the processor clock may run. Two events gate the processor clock for a settling time:
- a software request to move from the internal oscillator to the external one;
- a wake-up from suspend.

The settling time depends on the event. For external-oscillator events a register bit selects a long or a short delay. A wake on the internal oscillator always uses a short fixed delay. When the clock enable returns, the clock select moves to the requested source in the same cycle.

A low-voltage detect flag can also stop the processor. The register enables this response, and it is on by default. The processor clock is then held off for a start-up period. After that period a one-cycle restart strobe carries the restart address 0x0000, and the register keeps its contents. The register fields for the wake-up timer period, the low-voltage response, precise USB clocking and the clock-output disable are driven straight to output pins for neighbouring logic.

All delays are counted in cycles of the 6 MHz reference clock. The default lengths are:
- 768 cycles, for a 128 µs external delay;
- 24000 cycles, for a 4 ms external delay;
- 48 cycles, for an 8 µs internal wake.

The start-up period has its own parameter.

Top module: `osc_resume_ctrl`

## Requirements
- R1: After reset, `rd_data` is 0x00, `cpu_clk_en` is 1, and `ext_clk_sel`, `restart_pulse` and all field outputs are 0.
- R2: When `wr_en` is high and `wr_addr` equals 0xF8, `wr_data` is in `rd_data` from the next cycle. A write to any other address leaves `rd_data` unchanged. The field outputs follow the register fields: bits 6:4 go to `wake_period_sel`, bit 3 to `lvr_disable`, bit 2 to `usb_precise_en` and bit 1 to `clk_out_disable`.
- R3: While running on the internal clock, a write that sets bit 0 while bit 7 is 0 holds `cpu_clk_en` low for SHORT_EXT_CYC cycles. `cpu_clk_en` and `ext_clk_sel` then rise in the same cycle.
- R4: The same switch made with bit 7 set to 1 holds `cpu_clk_en` low for LONG_EXT_CYC cycles.
- R5: `suspend_req` drops `cpu_clk_en` on the next cycle, and it stays low until a wake.
- R6: A `wake_req` in suspend with bit 0 set gates the clock for LONG_EXT_CYC cycles if bit 7 is 1, or SHORT_EXT_CYC cycles if bit 7 is 0. The clock then resumes with `ext_clk_sel` at 1.
- R7: A `wake_req` in suspend with bit 0 clear gates the clock for INT_WAKE_CYC cycles whatever bit 7 holds. The clock then resumes with `ext_clk_sel` at 0.
- R8: A `suspend_req` during a settling delay aborts the delay and returns to suspend. The clock stays off until the next wake, which runs a full delay.
- R9: An accepted write with bit 0 clear sets `ext_clk_sel` to 0 on the next cycle. If the write lands during an external-oscillator delay, `cpu_clk_en` also returns to 1 on the next cycle.
- R10: With bit 3 at 0, `lv_detect` holds `cpu_clk_en` low for START_CYC cycles. The cycle in which `cpu_clk_en` returns carries a single-cycle `restart_pulse` with `restart_addr` at 0x0000. The register is unchanged, and suspend or wake requests during the hold have no effect.
- R11: With bit 3 at 1, `lv_detect` has no effect on `cpu_clk_en`.
- R12: When `lv_detect` (with bit 3 at 0) and `suspend_req` arrive in the same cycle, the low-voltage hold wins and ends in a restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 6 MHz reference clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Write address |
| wr_data | input | 8 | Write data |
| suspend_req | input | 1 | Enter suspend |
| wake_req | input | 1 | Wake from suspend |
| lv_detect | input | 1 | Supply below threshold |
| rd_data | output | 8 | Configuration register contents |
| ext_clk_sel | output | 1 | 1 selects the external oscillator |
| cpu_clk_en | output | 1 | Processor clock enable |
| restart_pulse | output | 1 | One-cycle restart strobe |
| restart_addr | output | 16 | Restart address, valid with the strobe |
| wake_period_sel | output | 3 | Wake-up timer period select |
| lvr_disable | output | 1 | Low-voltage response disabled |
| usb_precise_en | output | 1 | Precise USB clocking enable |
| clk_out_disable | output | 1 | Internal clock output disable |

## Verification
The bench builds the block with SHORT_EXT_CYC=6, LONG_EXT_CYC=20, INT_WAKE_CYC=3 and START_CYC=10. Because the three settling delays differ, a single count of gated cycles shows which delay the sequencer picked. The short windows also make it cheap to run many random configurations through suspend and wake. The same short windows let the bench land a suspend request or a bit-0 clear inside a delay, and requests inside the low-voltage hold, at a known cycle.

// File: rtl/osc_ctrl_pkg.sv
package osc_ctrl_pkg;

    typedef struct packed {
        logic       long_delay;   // bit 7
        logic [2:0] wake_adj;     // bits 6:4
        logic       lvr_off;      // bit 3
        logic       usb_precise;  // bit 2
        logic       clkout_off;   // bit 1
        logic       ext_en;       // bit 0
    } cfg_t;

    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_SUSP   = 2'd1,
        ST_SETTLE = 2'd2,
        ST_LVR    = 2'd3
    } seq_state_t;

    function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/osc_cfg_reg.sv
module osc_cfg_reg
    import osc_ctrl_pkg::*;
#(
    parameter logic [7:0] CFG_ADDR = 8'hF8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] wr_addr,
    input  logic [7:0] wr_data,
    output logic       cfg_wr,
    output cfg_t       wr_cfg,
    output cfg_t       cfg
);
    assign cfg_wr = wr_en && (wr_addr == CFG_ADDR);
    assign wr_cfg = cfg_t'(wr_data);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (cfg_wr) begin
            cfg <= wr_cfg;
        end
    end
endmodule

// File: rtl/osc_settle_timer.sv
module osc_settle_timer #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          zero
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/osc_seq_fsm.sv
module osc_seq_fsm
    import osc_ctrl_pkg::*;
#(
    parameter int CW            = 16,
    parameter int SHORT_EXT_CYC = 768,
    parameter int LONG_EXT_CYC  = 24000,
    parameter int INT_WAKE_CYC  = 48,
    parameter int START_CYC     = 3000
) (
    input  logic          clk,
    input  logic          rst,
    input  cfg_t          cfg,
    input  logic          cfg_wr,
    input  cfg_t          wr_cfg,
    input  logic          suspend_req,
    input  logic          wake_req,
    input  logic          lv_detect,
    input  logic          tmr_zero,
    output logic          tmr_load,
    output logic [CW-1:0] tmr_val,
    output seq_state_t    state,
    output logic          ext_sel,
    output logic          restart
);
    // Timer reload values: the timer expires after N cycles when loaded with N-1
    localparam logic [CW-1:0] L_SHORT = CW'(SHORT_EXT_CYC - 1);
    localparam logic [CW-1:0] L_LONG  = CW'(LONG_EXT_CYC - 1);
    localparam logic [CW-1:0] L_INT   = CW'(INT_WAKE_CYC - 1);
    localparam logic [CW-1:0] L_START = CW'(START_CYC - 1);

    seq_state_t nxt_state;
    logic       settle_ext, nxt_settle_ext;
    logic       nxt_ext_sel, nxt_restart;
    logic       lvr_trig, sw_trig, clr_ext;

    assign lvr_trig = lv_detect && !cfg.lvr_off;
    assign sw_trig  = cfg_wr && wr_cfg.ext_en && !cfg.ext_en;
    assign clr_ext  = cfg_wr && !wr_cfg.ext_en;

    always_comb begin
        nxt_state      = state;
        nxt_settle_ext = settle_ext;
        nxt_ext_sel    = clr_ext ? 1'b0 : ext_sel;
        nxt_restart    = 1'b0;
        tmr_load       = 1'b0;
        tmr_val        = L_START;
        unique case (state)
            ST_RUN: begin
                if (lvr_trig) begin
                    nxt_state = ST_LVR;
                    tmr_load  = 1'b1;
                end else if (suspend_req) begin
                    nxt_state = ST_SUSP;
                end else if (sw_trig) begin
                    nxt_state      = ST_SETTLE;
                    nxt_settle_ext = 1'b1;
                    tmr_load       = 1'b1;
                    tmr_val        = wr_cfg.long_delay ? L_LONG : L_SHORT;
                end
            end
            ST_SUSP: begin
                if (lvr_trig) begin
                    nxt_state = ST_LVR;
                    tmr_load  = 1'b1;
                end else if (wake_req) begin
                    nxt_state      = ST_SETTLE;
                    nxt_settle_ext = cfg.ext_en;
                    tmr_load       = 1'b1;
                    if (cfg.ext_en) tmr_val = cfg.long_delay ? L_LONG : L_SHORT;
                    else            tmr_val = L_INT;
                end
            end
            ST_SETTLE: begin
                if (lvr_trig) begin
                    nxt_state = ST_LVR;
                    tmr_load  = 1'b1;
                end else if (suspend_req) begin
                    nxt_state = ST_SUSP;
                end else if (settle_ext && clr_ext) begin
                    nxt_state = ST_RUN;
                end else if (tmr_zero) begin
                    nxt_state   = ST_RUN;
                    nxt_ext_sel = settle_ext;
                end
            end
            ST_LVR: begin
                if (tmr_zero) begin
                    nxt_state   = ST_RUN;
                    nxt_restart = 1'b1;
                end
            end
            default: nxt_state = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_RUN;
            settle_ext <= 1'b0;
            ext_sel    <= 1'b0;
            restart    <= 1'b0;
        end else begin
            state      <= nxt_state;
            settle_ext <= nxt_settle_ext;
            ext_sel    <= nxt_ext_sel;
            restart    <= nxt_restart;
        end
    end
endmodule

// File: rtl/osc_resume_ctrl.sv
module osc_resume_ctrl
    import osc_ctrl_pkg::*;
#(
    parameter logic [7:0]  CFG_ADDR      = 8'hF8,
    parameter logic [15:0] RESTART_VEC   = 16'h0000,
    parameter int          SHORT_EXT_CYC = 768,
    parameter int          LONG_EXT_CYC  = 24000,
    parameter int          INT_WAKE_CYC  = 48,
    parameter int          START_CYC     = 3000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [7:0]  wr_addr,
    input  logic [7:0]  wr_data,
    input  logic        suspend_req,
    input  logic        wake_req,
    input  logic        lv_detect,
    output logic [7:0]  rd_data,
    output logic        ext_clk_sel,
    output logic        cpu_clk_en,
    output logic        restart_pulse,
    output logic [15:0] restart_addr,
    output logic [2:0]  wake_period_sel,
    output logic        lvr_disable,
    output logic        usb_precise_en,
    output logic        clk_out_disable
);
    localparam int MAX_LEN = int'(max_of(max_of(SHORT_EXT_CYC, LONG_EXT_CYC),
                                         max_of(INT_WAKE_CYC, START_CYC)));
    localparam int CW = $clog2(MAX_LEN + 1);

    cfg_t          cfg, wr_cfg;
    logic          cfg_wr;
    logic          tmr_load, tmr_zero;
    logic [CW-1:0] tmr_val;
    seq_state_t    state;
    logic          restart;

    osc_cfg_reg #(.CFG_ADDR(CFG_ADDR)) u_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .cfg_wr  (cfg_wr),
        .wr_cfg  (wr_cfg),
        .cfg     (cfg)
    );

    osc_settle_timer #(.CW(CW)) u_tmr (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    osc_seq_fsm #(
        .CW            (CW),
        .SHORT_EXT_CYC (SHORT_EXT_CYC),
        .LONG_EXT_CYC  (LONG_EXT_CYC),
        .INT_WAKE_CYC  (INT_WAKE_CYC),
        .START_CYC     (START_CYC)
    ) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .cfg         (cfg),
        .cfg_wr      (cfg_wr),
        .wr_cfg      (wr_cfg),
        .suspend_req (suspend_req),
        .wake_req    (wake_req),
        .lv_detect   (lv_detect),
        .tmr_zero    (tmr_zero),
        .tmr_load    (tmr_load),
        .tmr_val     (tmr_val),
        .state       (state),
        .ext_sel     (ext_clk_sel),
        .restart     (restart)
    );

    assign rd_data         = cfg;
    assign cpu_clk_en      = (state == ST_RUN);
    assign restart_pulse   = restart;
    assign restart_addr    = restart ? RESTART_VEC : 16'h0000;
    assign wake_period_sel = cfg.wake_adj;
    assign lvr_disable     = cfg.lvr_off;
    assign usb_precise_en  = cfg.usb_precise;
    assign clk_out_disable = cfg.clkout_off;
endmodule

// File: rtl/osc_resume_ctrl_chk.sv
module osc_resume_ctrl_chk #(
    parameter logic [7:0] CFG_ADDR = 8'hF8
) (
    input logic        clk,
    input logic        rst,
    input logic        wr_en,
    input logic [7:0]  wr_addr,
    input logic [7:0]  wr_data,
    input logic        suspend_req,
    input logic        lv_detect,
    input logic [7:0]  rd_data,
    input logic        ext_clk_sel,
    input logic        cpu_clk_en,
    input logic        restart_pulse,
    input logic [15:0] restart_addr,
    input logic        lvr_disable
);
    assert_hold_cfg_R2: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && wr_addr == CFG_ADDR) |=> $stable(rd_data));

    assert_suspend_gates_R5: assert property (@(posedge clk) disable iff (rst)
        (suspend_req && cpu_clk_en) |=> !cpu_clk_en);

    assert_ext_with_enable_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(ext_clk_sel) |-> $rose(cpu_clk_en));

    assert_clear_ext_R9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == CFG_ADDR && !wr_data[0]) |=> !ext_clk_sel);

    assert_lv_gates_R10: assert property (@(posedge clk) disable iff (rst)
        (lv_detect && !lvr_disable && cpu_clk_en) |=> !cpu_clk_en);

    assert_restart_single_R10: assert property (@(posedge clk) disable iff (rst)
        restart_pulse |=> !restart_pulse);

    assert_restart_vector_R10: assert property (@(posedge clk) disable iff (rst)
        restart_pulse |-> (restart_addr == 16'h0000 && cpu_clk_en && $rose(cpu_clk_en)));
endmodule

bind osc_resume_ctrl osc_resume_ctrl_chk #(.CFG_ADDR(CFG_ADDR)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .wr_en         (wr_en),
    .wr_addr       (wr_addr),
    .wr_data       (wr_data),
    .suspend_req   (suspend_req),
    .lv_detect     (lv_detect),
    .rd_data       (rd_data),
    .ext_clk_sel   (ext_clk_sel),
    .cpu_clk_en    (cpu_clk_en),
    .restart_pulse (restart_pulse),
    .restart_addr  (restart_addr),
    .lvr_disable   (lvr_disable)
);

// File: tb/osc_resume_ctrl_test.sv
`timescale 1ns/1ps
module osc_resume_ctrl_test;
    localparam int SHORT = 6;
    localparam int LONG  = 20;
    localparam int INTW  = 3;
    localparam int START = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = 8'h00;
    logic [7:0]  wr_data = 8'h00;
    logic        suspend_req = 1'b0;
    logic        wake_req = 1'b0;
    logic        lv_detect = 1'b0;
    logic [7:0]  rd_data;
    logic        ext_clk_sel, cpu_clk_en, restart_pulse;
    logic [15:0] restart_addr;
    logic [2:0]  wake_period_sel;
    logic        lvr_disable, usb_precise_en, clk_out_disable;

    int checks = 0;
    int fails  = 0;
    int n;
    logic last_restart;
    logic [15:0] last_addr;

    always #4 clk = ~clk;

    osc_resume_ctrl #(
        .SHORT_EXT_CYC (SHORT),
        .LONG_EXT_CYC  (LONG),
        .INT_WAKE_CYC  (INTW),
        .START_CYC     (START)
    ) uut (
        .clk, .rst, .wr_en, .wr_addr, .wr_data, .suspend_req, .wake_req, .lv_detect,
        .rd_data, .ext_clk_sel, .cpu_clk_en, .restart_pulse, .restart_addr,
        .wake_period_sel, .lvr_disable, .usb_precise_en, .clk_out_disable
    );

    function automatic int exp_len(input logic ext, input logic lng);
        return ext ? (lng ? LONG : SHORT) : INTW;
    endfunction

    task automatic check(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input int act, input int exp);
        check(act == exp, req, act, exp);
    endtask

    // Inputs already driven at this negedge; clear them after one edge and
    // count the samples with the clock enable low.
    task automatic trig_count(output int cnt);
        @(negedge clk);
        wr_en = 1'b0; suspend_req = 1'b0; wake_req = 1'b0; lv_detect = 1'b0;
        cnt = 0;
        while (!cpu_clk_en && cnt < 1000) begin
            cnt++;
            @(negedge clk);
        end
        last_restart = restart_pulse;
        last_addr    = restart_addr;
    endtask

    task automatic drive_wr(input logic [7:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
    endtask

    task automatic do_suspend();
        suspend_req = 1'b1;
        @(negedge clk);
        suspend_req = 1'b0;
    endtask

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] d, cur;
        logic ext_m;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk_eq("R1 rd_data", rd_data, 0);
        chk_eq("R1 cpu_clk_en", cpu_clk_en, 1);
        chk_eq("R1 ext_clk_sel", ext_clk_sel, 0);
        chk_eq("R1 restart", restart_pulse, 0);
        chk_eq("R1 fields", {wake_period_sel, lvr_disable, usb_precise_en, clk_out_disable}, 0);

        // R2 field mapping, wrong address ignored
        drive_wr(8'hF8, 8'h5E); trig_count(n);
        chk_eq("R2 readback", rd_data, 8'h5E);
        chk_eq("R2 wake_period_sel", wake_period_sel, 5);
        chk_eq("R2 lvr/usb/clkout", {lvr_disable, usb_precise_en, clk_out_disable}, 3'b111);
        drive_wr(8'hF7, 8'hFF); trig_count(n);
        chk_eq("R2 wrong address", rd_data, 8'h5E);
        chk_eq("R2 wrong address no gating", n, 0);

        // R3 short switch
        drive_wr(8'hF8, 8'h09); trig_count(n);
        chk_eq("R3 short switch delay", n, SHORT);
        chk_eq("R3 ext_clk_sel", ext_clk_sel, 1);
        // R9 clear from running on external
        drive_wr(8'hF8, 8'h08); trig_count(n);
        chk_eq("R9 ext cleared", ext_clk_sel, 0);
        chk_eq("R9 clock kept", n, 0);
        // R4 long switch
        drive_wr(8'hF8, 8'h89); trig_count(n);
        chk_eq("R4 long switch delay", n, LONG);
        chk_eq("R4 ext_clk_sel", ext_clk_sel, 1);

        // R5 suspend, R6 wake long external
        do_suspend();
        chk_eq("R5 gated after suspend", cpu_clk_en, 0);
        repeat (30) @(negedge clk);
        chk_eq("R5 stays gated", cpu_clk_en, 0);
        wake_req = 1'b1; trig_count(n);
        chk_eq("R6 long wake delay", n, LONG);
        chk_eq("R6 ext_clk_sel", ext_clk_sel, 1);

        // R7 internal wake ignores bit 7
        drive_wr(8'hF8, 8'h88); trig_count(n);
        do_suspend();
        wake_req = 1'b1; trig_count(n);
        chk_eq("R7 internal wake delay", n, INTW);
        chk_eq("R7 ext_clk_sel", ext_clk_sel, 0);

        // R8 abort settle by suspend
        drive_wr(8'hF8, 8'h89); trig_count(n);
        do_suspend();
        wake_req = 1'b1;
        @(negedge clk); wake_req = 1'b0;
        repeat (4) @(negedge clk);
        do_suspend();
        repeat (LONG + 5) @(negedge clk);
        chk_eq("R8 back in suspend", cpu_clk_en, 0);
        wake_req = 1'b1; trig_count(n);
        chk_eq("R8 full delay after abort", n, LONG);

        // R9 clear during external settle
        drive_wr(8'hF8, 8'h88); trig_count(n);
        drive_wr(8'hF8, 8'h89);
        @(negedge clk); wr_en = 1'b0;
        repeat (3) @(negedge clk);
        chk_eq("R9 in settle", cpu_clk_en, 0);
        drive_wr(8'hF8, 8'h88);
        @(negedge clk); wr_en = 1'b0;
        chk_eq("R9 clock back at once", cpu_clk_en, 1);
        chk_eq("R9 internal select", ext_clk_sel, 0);

        // R10 low-voltage hold with requests ignored
        drive_wr(8'hF8, 8'h52); trig_count(n);
        lv_detect = 1'b1;
        @(negedge clk); lv_detect = 1'b0;
        n = 1;
        suspend_req = 1'b1; wake_req = 1'b1;
        @(negedge clk); suspend_req = 1'b0; wake_req = 1'b0;
        n++;
        while (!cpu_clk_en && n < 1000) begin n++; @(negedge clk); end
        n--;
        chk_eq("R10 start period", n, START);
        chk_eq("R10 restart pulse", restart_pulse, 1);
        chk_eq("R10 restart address", restart_addr, 0);
        chk_eq("R10 register kept", rd_data, 8'h52);
        @(negedge clk);
        chk_eq("R10 single pulse", restart_pulse, 0);
        chk_eq("R10 requests ignored", cpu_clk_en, 1);

        // R11 disabled response
        drive_wr(8'hF8, 8'h08); trig_count(n);
        lv_detect = 1'b1; trig_count(n);
        chk_eq("R11 lv ignored", n, 0);
        @(negedge clk);
        chk_eq("R11 still running", cpu_clk_en, 1);

        // R12 priority of low voltage over suspend
        drive_wr(8'hF8, 8'h00); trig_count(n);
        lv_detect = 1'b1; suspend_req = 1'b1; trig_count(n);
        chk_eq("R12 hold length", n, START);
        chk_eq("R12 restart", last_restart, 1);
        chk_eq("R12 restart address", last_addr, 0);

        // Random configurations through switch, suspend and wake (R2 R3 R4 R6 R7)
        drive_wr(8'hF8, 8'h08); trig_count(n);
        cur = 8'h08; ext_m = 1'b0;
        for (int i = 0; i < 40; i++) begin
            d = 8'($urandom);
            d[3] = 1'b1;
            if (($urandom % 5) == 0) begin
                drive_wr(8'hF8 ^ 8'(1 + $urandom % 255), d); trig_count(n);
                chk_eq("R2 random wrong address", rd_data, cur);
                continue;
            end
            drive_wr(8'hF8, d); trig_count(n);
            chk_eq("R3 R4 random switch delay", n, (d[0] && !cur[0]) ? exp_len(1'b1, d[7]) : 0);
            ext_m = d[0];
            chk_eq("R2 random readback", rd_data, d);
            chk_eq("R9 R3 random select", ext_clk_sel, ext_m);
            cur = d;
            do_suspend();
            wake_req = 1'b1; trig_count(n);
            chk_eq("R6 R7 random wake delay", n, exp_len(d[0], d[7]));
            chk_eq("R6 R7 random select", ext_clk_sel, d[0]);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule